// File: doc/BRIEF.md
# Dual-FIFO Inter-Processor Mailbox

This block lets an application processor and an I/O co-processor pass short messages to each other through one shared register window. Two independent message queues live inside it: the outbound queue carries traffic from the application side to the I/O side, and the inbound queue carries traffic the other way. Each message is a 64-bit word plus a 32-bit word. Either processor may use any register. By convention the application side sends on the outbound queue and drains the inbound one.

A sender writes the 64-bit word to the first send register and then writes the 32-bit word to the second send register. The second write commits the whole message as one entry. A receiver reads the first receive register to see the 64-bit word of the head entry. It then reads the second receive register, which returns the 32-bit word together with a snapshot of that queue's pointers and counts, and removes the entry. Four sticky interrupt sources record an empty or a non-empty condition on either queue. An enable mask reduces them to two level interrupt lines, send-empty and receive-not-empty.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset both queues report empty (control bit 17 = 1) and not full (bit 16 = 0), the enable register (byte address 0x48) reads 0, and both interrupt outputs are low.
- R2: A write to a queue's first send register (outbound 0x60, inbound 0x90) changes no queue state. A write to the second send register (0x68 / 0x98) enqueues one entry made of the latched first word and bits [31:0] of the written data.
- R3: Entries leave each queue in the order they were committed. The first receive register (0x70 / 0xA0) returns the head's 64-bit word. A read of the second receive register (0x78 / 0xA8) returns the head's 32-bit word in bits [31:0] and pops the entry.
- R4: A read of the second receive register reports the state before the pop: bits [43:40] write pointer, [47:44] read pointer, [51:48] free slots saturated at 15, [56:52] occupancy. Bits [39:32] and [63:57] read 0.
- R5: A queue's control register (outbound 0x50, inbound 0x80) shows full in bit 16 and empty in bit 17. Traffic on one queue leaves the other queue's status unchanged.
- R6: A commit to a full queue is dropped and sets a sticky overflow flag in control bit 18. Writing a 1 to bit 18 of that control register clears the flag.
- R7: A pop from an empty queue returns zero in the 64-bit word and in bits [31:0], and leaves the pointers unchanged.
- R8: The raw interrupt sources read at 0x4C are: bit 0 outbound empty, bit 1 outbound not-empty, bit 2 inbound empty, bit 3 inbound not-empty. A source latches the cycle after its condition is true and stays set after the condition goes away.
- R9: Writing a 1 to a bit of 0x4C clears that source in that cycle. If its condition still holds, the source sets again one cycle later.
- R10: send-empty is the OR of sources 0 and 2 under the enable mask. receive-not-empty is the OR of sources 1 and 3 under the mask. With a mask bit at 0, that source has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe, one cycle per access |
| bus_rd | input | 1 | Register read strobe. A read of a second receive register pops |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, valid in the same cycle as bus_rd |
| irq_send_empty | output | 1 | Level interrupt: an enabled empty source is set |
| irq_recv_not_empty | output | 1 | Level interrupt: an enabled not-empty source is set |

## Verification
The hardest behaviour to reach from the ports is the one-cycle gap in R9. After an acknowledge, a source whose condition still holds reads 0 for exactly one cycle and then returns. The bench writes the acknowledge and reads 0x4C in each of the next two cycles with no idle cycle between them. It also makes sticky sources outlive their conditions, by pushing into an empty queue and then draining it, so that the empty and the not-empty source of the same queue are both set at once. The overflow path is reached by filling a queue to its depth plus one. The bench then drains it and checks that the dropped message never appears and that the pointer fields wrapped.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Register byte addresses. Each channel's block of registers repeats at a fixed stride.
  localparam int ADR_IRQ_EN  = 32'h48;
  localparam int ADR_IRQ_ACK = 32'h4C;
  localparam int ADR_CH_BASE = 32'h50;
  localparam int CH_STRIDE   = 32'h30;
  localparam int OFS_CTRL    = 32'h00;
  localparam int OFS_SEND0   = 32'h10;
  localparam int OFS_SEND1   = 32'h18;
  localparam int OFS_RECV0   = 32'h20;
  localparam int OFS_RECV1   = 32'h28;

  // Bit positions in the control word.
  localparam int CTRL_FULL_BIT  = 16;
  localparam int CTRL_EMPTY_BIT = 17;
  localparam int CTRL_OVF_BIT   = 18;

  // Lowest bit of each status field in the second receive word.
  localparam int FLD_WPTR_LSB = 40;
  localparam int FLD_RPTR_LSB = 44;
  localparam int FLD_FREE_LSB = 48;
  localparam int FLD_OCC_LSB  = 52;

  typedef struct packed {
    logic [63:0] wide;
    logic [31:0] narrow;
  } msg_t;

endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo
  import mbx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push,
  input  logic                      pop,
  input  logic                      ovf_clr,
  input  msg_t                      wdata,
  output msg_t                      head,
  output logic                      full,
  output logic                      empty,
  output logic                      ovf,
  output logic [$clog2(DEPTH)-1:0]  wptr,
  output logic [$clog2(DEPTH)-1:0]  rptr,
  output logic [$clog2(DEPTH):0]    count
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  msg_t mem [DEPTH];

  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             push_ok, pop_ok;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (push_ok) wptr_d = (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
    if (pop_ok)  rptr_d = (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
    // A dropped commit wins over a clear in the same cycle.
    ovf_d = (push & full) | (ovf_q & ~ovf_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
      ovf_q  <= ovf_d;
    end
  end

  // The storage array is not reset. An entry is read only after it has been written.
  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= wdata;
  end

  assign head  = empty ? '0 : mem[rptr_q];
  assign ovf   = ovf_q;
  assign wptr  = wptr_q;
  assign rptr  = rptr_q;
  assign count = cnt_q;

endmodule

// File: rtl/mbx_irq.sv
module mbx_irq #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] cond,
  input  logic [NSRC-1:0] ack,
  output logic [NSRC-1:0] src
);

  logic [NSRC-1:0] src_q, src_d;

  // An acknowledge clears the latch for one cycle. A condition that persists sets it again on the next edge.
  always_comb begin
    src_d = ~ack & (src_q | cond);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src_d;
  end

  assign src = src_q;

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import mbx_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [63:0]       bus_wdata,
  output logic [63:0]       bus_rdata,
  output logic              irq_send_empty,
  output logic              irq_recv_not_empty
);

  localparam int NCH   = 2;
  localparam int NSRC  = 2 * NCH;
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  // Reset is asserted at once and released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  logic [NCH-1:0]             fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic [NCH-1:0]             fifo_ovf, fifo_ovf_clr;
  logic [NCH-1:0][PTR_W-1:0]  fifo_wptr, fifo_rptr;
  logic [NCH-1:0][CNT_W-1:0]  fifo_cnt;
  msg_t [NCH-1:0]             fifo_head, fifo_in;
  logic [NCH-1:0][63:0]       ch_rdata;

  logic [NSRC-1:0] irq_cond, irq_ack, irq_src, irq_en_q, irq_live;
  logic            hit_en, hit_ack, en_we;

  assign hit_en  = (bus_addr == ADDR_W'(ADR_IRQ_EN));
  assign hit_ack = (bus_addr == ADDR_W'(ADR_IRQ_ACK));
  assign en_we   = bus_wr & hit_en;
  assign irq_ack = {NSRC{bus_wr & hit_ack}} & bus_wdata[NSRC-1:0];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(ADR_CH_BASE + ch * CH_STRIDE);

    logic        hit_ctrl, hit_s0, hit_s1, hit_r0, hit_r1;
    logic        stage_we;
    logic [63:0] stage_q;
    logic [CNT_W-1:0] free_slots;
    logic [3:0]  free_fld, wp_fld, rp_fld;
    logic [4:0]  occ_fld;
    logic [63:0] ctrl_word, stat_word;

    assign hit_ctrl = (bus_addr == BASE + ADDR_W'(OFS_CTRL));
    assign hit_s0   = (bus_addr == BASE + ADDR_W'(OFS_SEND0));
    assign hit_s1   = (bus_addr == BASE + ADDR_W'(OFS_SEND1));
    assign hit_r0   = (bus_addr == BASE + ADDR_W'(OFS_RECV0));
    assign hit_r1   = (bus_addr == BASE + ADDR_W'(OFS_RECV1));

    // The first send word waits in this register until the second send write commits the pair.
    assign stage_we = bus_wr & hit_s0;
    always_ff @(posedge clk or negedge rst_n_s) begin
      if (!rst_n_s)      stage_q <= '0;
      else if (stage_we) stage_q <= bus_wdata;
    end

    assign fifo_push[ch]    = bus_wr & hit_s1;
    assign fifo_pop[ch]     = bus_rd & hit_r1;
    assign fifo_ovf_clr[ch] = bus_wr & hit_ctrl & bus_wdata[CTRL_OVF_BIT];
    assign fifo_in[ch]      = '{wide: stage_q, narrow: bus_wdata[31:0]};

    mbx_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .push    (fifo_push[ch]),
      .pop     (fifo_pop[ch]),
      .ovf_clr (fifo_ovf_clr[ch]),
      .wdata   (fifo_in[ch]),
      .head    (fifo_head[ch]),
      .full    (fifo_full[ch]),
      .empty   (fifo_empty[ch]),
      .ovf     (fifo_ovf[ch]),
      .wptr    (fifo_wptr[ch]),
      .rptr    (fifo_rptr[ch]),
      .count   (fifo_cnt[ch])
    );

    assign free_slots = CNT_W'(DEPTH) - fifo_cnt[ch];
    assign free_fld   = (free_slots > CNT_W'(15)) ? 4'hF : 4'(free_slots);
    assign occ_fld    = 5'(fifo_cnt[ch]);
    assign wp_fld     = 4'(fifo_wptr[ch]);
    assign rp_fld     = 4'(fifo_rptr[ch]);

    always_comb begin
      ctrl_word = '0;
      ctrl_word[CTRL_FULL_BIT]  = fifo_full[ch];
      ctrl_word[CTRL_EMPTY_BIT] = fifo_empty[ch];
      ctrl_word[CTRL_OVF_BIT]   = fifo_ovf[ch];

      stat_word = '0;
      stat_word[31:0]                = fifo_head[ch].narrow;
      stat_word[FLD_WPTR_LSB +: 4]   = wp_fld;
      stat_word[FLD_RPTR_LSB +: 4]   = rp_fld;
      stat_word[FLD_FREE_LSB +: 4]   = free_fld;
      stat_word[FLD_OCC_LSB  +: 5]   = occ_fld;

      ch_rdata[ch] = '0;
      if (hit_ctrl) ch_rdata[ch] = ctrl_word;
      if (hit_r0)   ch_rdata[ch] = fifo_head[ch].wide;
      if (hit_r1)   ch_rdata[ch] = stat_word;
    end

    // Even-numbered sources track empty, odd-numbered sources track not-empty.
    assign irq_cond[2*ch]     = fifo_empty[ch];
    assign irq_cond[2*ch + 1] = ~fifo_empty[ch];
  end

  mbx_irq #(.NSRC(NSRC)) u_irq (
    .clk   (clk),
    .rst_n (rst_n_s),
    .cond  (irq_cond),
    .ack   (irq_ack),
    .src   (irq_src)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)   irq_en_q <= '0;
    else if (en_we) irq_en_q <= bus_wdata[NSRC-1:0];
  end

  // The enable mask is applied after the sticky latch, so a masked source keeps its state.
  assign irq_live = irq_src & irq_en_q;

  always_comb begin
    irq_send_empty     = 1'b0;
    irq_recv_not_empty = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (i % 2 == 0) irq_send_empty     = irq_send_empty | irq_live[i];
      else            irq_recv_not_empty = irq_recv_not_empty | irq_live[i];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (hit_en)  bus_rdata[NSRC-1:0] = irq_en_q;
      if (hit_ack) bus_rdata[NSRC-1:0] = irq_src;
      for (int c = 0; c < NCH; c++) bus_rdata = bus_rdata | ch_rdata[c];
    end
  end

endmodule

// File: rtl/mbx_chk.sv
module mbx_chk
  import mbx_pkg::*;
#(
  parameter int PTR_W  = 4,
  parameter int ADDR_W = 8,
  parameter int NCH    = 2,
  parameter int NSRC   = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_wr,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [NSRC-1:0]           ack_bits,
  input logic [NCH-1:0]            fifo_push,
  input logic [NCH-1:0]            fifo_pop,
  input logic [NCH-1:0]            fifo_full,
  input logic [NCH-1:0]            fifo_empty,
  input logic [NCH-1:0]            fifo_ovf,
  input logic [NCH-1:0][PTR_W-1:0] fifo_rptr,
  input logic [NSRC-1:0]           irq_src,
  input logic [NSRC-1:0]           irq_en_q,
  input logic                      irq_send_empty,
  input logic                      irq_recv_not_empty
);

  logic ack_wr;
  assign ack_wr = bus_wr && (bus_addr == ADDR_W'(ADR_IRQ_ACK));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    // R5: a queue is never full and empty at the same time
    a_r5_full_empty_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(fifo_full[c] && fifo_empty[c]));

    // R6: a commit to a full queue raises the overflow flag
    a_r6_overflow_set: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_push[c] && fifo_full[c] |=> fifo_ovf[c]);

    // R6: a dropped commit leaves the queue full
    a_r6_drop_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_push[c] && fifo_full[c] && !fifo_pop[c] |=> fifo_full[c]);

    // R7: a pop from an empty queue leaves the read pointer where it was
    a_r7_empty_pop_still: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop[c] && fifo_empty[c] && !fifo_push[c] |=> $stable(fifo_rptr[c]) && fifo_empty[c]);
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic cond_i;
    if (i % 2 == 1) begin : g_ne
      assign cond_i = !fifo_empty[i/2];
    end else begin : g_e
      assign cond_i = fifo_empty[i/2];
    end

    // R8: a present condition with no acknowledge latches the source
    a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
      cond_i && !(ack_wr && ack_bits[i]) |=> irq_src[i]);

    // R8: a set source holds until acknowledged
    a_r8_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
      irq_src[i] && !(ack_wr && ack_bits[i]) |=> irq_src[i]);

    // R9: an acknowledge clears the source on the next edge
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ack_wr && ack_bits[i] |=> !irq_src[i]);
  end

  // R10: with no enables set, both interrupt lines stay low
  a_r10_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en_q == '0) |-> !irq_send_empty && !irq_recv_not_empty);

  // R10: send-empty needs an enabled empty source
  a_r10_send_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    irq_send_empty |-> (irq_src[0] && irq_en_q[0]) || (irq_src[2] && irq_en_q[2]));

endmodule

bind ipc_mailbox mbx_chk #(
  .PTR_W  (PTR_W),
  .ADDR_W (ADDR_W),
  .NCH    (NCH),
  .NSRC   (NSRC)
) u_mbx_chk (
  .clk                (clk),
  .rst_n              (rst_n_s),
  .bus_wr             (bus_wr),
  .bus_addr           (bus_addr),
  .ack_bits           (bus_wdata[NSRC-1:0]),
  .fifo_push          (fifo_push),
  .fifo_pop           (fifo_pop),
  .fifo_full          (fifo_full),
  .fifo_empty         (fifo_empty),
  .fifo_ovf           (fifo_ovf),
  .fifo_rptr          (fifo_rptr),
  .irq_src            (irq_src),
  .irq_en_q           (irq_en_q),
  .irq_send_empty     (irq_send_empty),
  .irq_recv_not_empty (irq_recv_not_empty)
);

// File: tb/test_ipc_mailbox.sv
`timescale 1ns/1ps
module test_ipc_mailbox;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_addr;
  logic [63:0] bus_wdata;
  logic [63:0] bus_rdata;
  logic        irq_send_empty, irq_recv_not_empty;

  always #2 clk = ~clk;

  ipc_mailbox #(.DEPTH(DEPTH), .ADDR_W(8)) i_ipc_mailbox (
    .clk                (clk),
    .rst_n              (rst_n),
    .bus_wr             (bus_wr),
    .bus_rd             (bus_rd),
    .bus_addr           (bus_addr),
    .bus_wdata          (bus_wdata),
    .bus_rdata          (bus_rdata),
    .irq_send_empty     (irq_send_empty),
    .irq_recv_not_empty (irq_recv_not_empty)
  );

  int nchk = 0;
  int nerr = 0;

  // Scoreboard: expected messages per queue, plus a pointer model.
  logic [95:0] sb_out[$];
  logic [95:0] sb_in[$];
  int m_wp[2];
  int m_rp[2];

  function automatic logic [7:0] adr(int ch, int ofs);
    return 8'(8'h50 + ch * 8'h30 + ofs);
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Both tasks start and end at a falling edge.
  task automatic wr(logic [7:0] a, logic [63:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [63:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic int qsize(int ch);
    return (ch == 0) ? sb_out.size() : sb_in.size();
  endfunction

  // Driver: commits a message and records what the queue should hold.
  task automatic send_msg(int ch, logic [63:0] w0, logic [31:0] w1);
    wr(adr(ch, 8'h10), w0);
    wr(adr(ch, 8'h18), {32'hDEAD_BEEF, w1});
    if (qsize(ch) < DEPTH) begin
      if (ch == 0) sb_out.push_back({w0, w1});
      else         sb_in.push_back({w0, w1});
      m_wp[ch] = (m_wp[ch] + 1) % DEPTH;
    end
  endtask

  // Monitor: reads the head entry and compares it with the scoreboard.
  task automatic recv_msg(int ch);
    logic [63:0] g0, g1, exp_stat;
    logic [95:0] e;
    int cnt, fr;
    cnt = qsize(ch);
    fr  = (DEPTH - cnt > 15) ? 15 : DEPTH - cnt;
    exp_stat = '0;
    exp_stat[43:40] = 4'(m_wp[ch]);
    exp_stat[47:44] = 4'(m_rp[ch]);
    exp_stat[51:48] = 4'(fr);
    exp_stat[56:52] = 5'(cnt);
    rd(adr(ch, 8'h20), g0);
    rd(adr(ch, 8'h28), g1);
    if (cnt > 0) begin
      e = (ch == 0) ? sb_out.pop_front() : sb_in.pop_front();
      chk("R3 wide word", g0, e[95:32]);
      chk("R3 narrow word", {32'h0, g1[31:0]}, {32'h0, e[31:0]});
      m_rp[ch] = (m_rp[ch] + 1) % DEPTH;
    end else begin
      chk("R7 empty wide word", g0, 64'h0);
      chk("R7 empty narrow word", {32'h0, g1[31:0]}, 64'h0);
    end
    chk("R4 status fields", {g1[63:32], 32'h0}, exp_stat);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [63:0] d;
    m_wp[0] = 0; m_wp[1] = 0; m_rp[0] = 0; m_rp[1] = 0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    rd(8'h50, d); chk("R1 outbound ctrl", d, 64'h2_0000);
    rd(8'h80, d); chk("R1 inbound ctrl", d, 64'h2_0000);
    rd(8'h48, d); chk("R1 enable", d, 64'h0);
    chk("R1 irq lines", {62'h0, irq_send_empty, irq_recv_not_empty}, 64'h0);
    rd(8'h4C, d); chk("R8 sources after reset", d, 64'h5);

    // R2: a first-word write alone changes nothing
    wr(8'h60, 64'h1234_5678_9ABC_DEF0);
    rd(8'h50, d); chk("R2 ctrl after first word", d, 64'h2_0000);
    @(negedge clk);
    rd(8'h4C, d); chk("R2 no not-empty source", d, 64'h5);

    // R3/R4: ordering across several patterns on both queues
    send_msg(0, 64'h0123_4567_89AB_CDEF, 32'h1111_1111);
    send_msg(0, 64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF);
    send_msg(1, 64'h5555_5555_5555_5555, 32'hAAAA_AAAA);
    send_msg(0, 64'h0, 32'h0000_0001);
    send_msg(1, 64'h8000_0000_0000_0001, 32'h8000_0000);
    rd(8'h50, d); chk("R5 outbound neither full nor empty", d, 64'h0);
    recv_msg(1);
    recv_msg(0);
    recv_msg(0);
    recv_msg(1);
    recv_msg(0);

    // R5/R6: fill the outbound queue, then push one more
    for (int i = 0; i < DEPTH; i++)
      send_msg(0, 64'hA000_0000_0000_0000 + 64'(i), 32'hC000_0000 | 32'(i));
    rd(8'h50, d); chk("R5 outbound full", d, 64'h1_0000);
    rd(8'h80, d); chk("R5 inbound independent", d, 64'h2_0000);
    send_msg(0, 64'hBAD0_BAD0_BAD0_BAD0, 32'hBAD0_0000);
    rd(8'h50, d); chk("R6 overflow flagged", d, 64'h5_0000);
    for (int i = 0; i < DEPTH; i++) recv_msg(0);
    rd(8'h50, d); chk("R6 overflow sticky after drain", d, 64'h6_0000);
    wr(8'h50, 64'h4_0000);
    rd(8'h50, d); chk("R6 overflow cleared", d, 64'h2_0000);

    // R7: pops from an empty queue
    rd(8'hA0, d); chk("R7 empty first word", d, 64'h0);
    recv_msg(1);
    recv_msg(1);

    // R9: acknowledge with the condition still present
    wr(8'h4C, 64'hF);
    rd(8'h4C, d); chk("R9 cleared cycle", d, 64'h0);
    rd(8'h4C, d); chk("R9 reasserted", d, 64'h5);

    // R8: sticky sources outlive their conditions
    send_msg(0, 64'h7777_0000_7777_0000, 32'h7777_7777);
    @(negedge clk);
    rd(8'h4C, d); chk("R8 empty held while not empty", d, 64'h7);
    wr(8'h4C, 64'h1);
    rd(8'h4C, d); chk("R9 cleared without condition", d, 64'h6);
    rd(8'h4C, d); chk("R9 no reassert without condition", d, 64'h6);
    recv_msg(0);
    @(negedge clk);
    rd(8'h4C, d); chk("R8 not-empty held after drain", d, 64'h7);
    wr(8'h4C, 64'h2);
    @(negedge clk);
    rd(8'h4C, d); chk("R8 after ack of not-empty", d, 64'h5);

    // R10: the mask picks which sources drive the lines
    chk("R10 masked lines", {62'h0, irq_send_empty, irq_recv_not_empty}, 64'h0);
    wr(8'h48, 64'h4);
    chk("R10 inbound empty enabled", {62'h0, irq_send_empty, irq_recv_not_empty}, 64'h2);
    rd(8'h48, d); chk("R10 enable readback", d, 64'h4);
    wr(8'h48, 64'h8);
    chk("R10 only inbound not-empty enabled", {62'h0, irq_send_empty, irq_recv_not_empty}, 64'h0);
    send_msg(1, 64'h0BAD_F00D_0BAD_F00D, 32'h1357_9BDF);
    @(negedge clk);
    chk("R10 receive line up", {62'h0, irq_send_empty, irq_recv_not_empty}, 64'h1);
    recv_msg(1);
    wr(8'h4C, 64'h8);
    chk("R10 receive line down after ack", {62'h0, irq_send_empty, irq_recv_not_empty}, 64'h0);
    wr(8'h48, 64'h2);
    send_msg(0, 64'h2468_ACE0_2468_ACE0, 32'h0F0F_0F0F);
    @(negedge clk);
    chk("R10 outbound not-empty drives receive line", {62'h0, irq_send_empty, irq_recv_not_empty}, 64'h1);
    recv_msg(0);
    wr(8'h48, 64'h0);
    chk("R10 all masked", {62'h0, irq_send_empty, irq_recv_not_empty}, 64'h0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule